// File: doc/BRIEF.md
# Bit-Sliced Eight-Bit ALU with Signed Less-Than

A purely combinational arithmetic logic unit that works on two 8-bit operands under a 3-bit opcode. It gives an 8-bit result and one overflow flag. The datapath is a chain of identical one-bit slices.

Each slice can invert either operand bit through an XOR. It then picks its output from four sources: an AND gate, an OR gate, its full-adder sum, or a `less` input. NAND and NOR reuse the OR and AND gates on inverted operands, by De Morgan, so the slices hold no extra gates for them. A small decoder turns the opcode into the slice controls and the carry into bit 0.

A separate piece of glue logic handles two things. It compares the carry into the top slice with the carry out of it to detect signed overflow. It also corrects the top slice's raw sum with that overflow to form the signed less-than bit, which goes into bit 0 of the result. Operands are two's-complement for overflow and comparison.

Top module: `bitslice_alu`

## Requirements
- R1: With op 0 (encoding 3'd0), result equals a AND b.
- R2: With op 1 (3'd1), result equals a OR b.
- R3: With op 2 (3'd2), result equals NOT(a AND b), formed from the OR path on inverted operands.
- R4: With op 3 (3'd3), result equals NOT(a OR b), formed from the AND path on inverted operands.
- R5: With op 4 (3'd4), result equals (a + b) mod 256.
- R6: With op 5 (3'd5), result equals (a - b) mod 256.
- R7: With op 4, overflow is 1 exactly when the signed sum of a and b lies outside -128..127.
- R8: With op 5, overflow is 1 exactly when the signed difference a - b lies outside -128..127.
- R9: With op 6 (3'd6), result bit 0 is 1 exactly when a < b as signed values, including when a - b overflows. Result bits 7..1 are 0.
- R10: With ops 0, 1, 2, 3 and 6, the overflow output is 0.
- R11: The block holds no state. Both outputs follow the present inputs in the same time step. With a = b = 0 under op 0, both outputs are 0.

Opcode 7 is never applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand (two's complement) |
| b_i | input | 8 | Second operand (two's complement) |
| op_i | input | 3 | Opcode, 0..6 |
| result_o | output | 8 | Operation result |
| overflow_o | output | 1 | Signed overflow for add and subtract |

## Verification
Both outputs are combinational, so every result is due in the same time step as the stimulus, with zero clock cycles of latency. The bench applies one operand pair and opcode every nanosecond and samples half a nanosecond later, so the outputs have settled and the next stimulus has not yet arrived. It sweeps all operand pairs under all seven opcodes. It also checks named extreme pairs (0x7F, 0x80, 0x00, 0xFF) and less-than cases whose subtraction overflows, each against a value worked out by hand.

// File: rtl/bitslice_alu_pkg.sv
package bitslice_alu_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_NAND = 3'd2,
    OP_NOR  = 3'd3,
    OP_ADD  = 3'd4,
    OP_SUB  = 3'd5,
    OP_SLT  = 3'd6
  } alu_op_e;

  // Per-slice output select
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  typedef struct packed {
    logic       inv_a;
    logic       inv_b;
    logic       carry0;
    slice_sel_e sel;
    logic       ovf_en;
  } slice_ctrl_t;

endpackage

// File: rtl/alu_ctrl_dec.sv
module alu_ctrl_dec
  import bitslice_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output slice_ctrl_t     ctrl_o
);

  always_comb begin
    ctrl_o = '{inv_a: 1'b0, inv_b: 1'b0, carry0: 1'b0, sel: SEL_AND, ovf_en: 1'b0};
    unique case (op_i)
      OP_AND:  ctrl_o.sel = SEL_AND;
      OP_OR:   ctrl_o.sel = SEL_OR;
      OP_NAND: begin
        ctrl_o.inv_a = 1'b1;
        ctrl_o.inv_b = 1'b1;
        ctrl_o.sel   = SEL_OR;
      end
      OP_NOR: begin
        ctrl_o.inv_a = 1'b1;
        ctrl_o.inv_b = 1'b1;
        ctrl_o.sel   = SEL_AND;
      end
      OP_ADD: begin
        ctrl_o.sel    = SEL_SUM;
        ctrl_o.ovf_en = 1'b1;
      end
      OP_SUB: begin
        ctrl_o.inv_b  = 1'b1;
        ctrl_o.carry0 = 1'b1;
        ctrl_o.sel    = SEL_SUM;
        ctrl_o.ovf_en = 1'b1;
      end
      OP_SLT: begin
        ctrl_o.inv_b  = 1'b1;
        ctrl_o.carry0 = 1'b1;
        ctrl_o.sel    = SEL_LESS;
      end
      default: ctrl_o.sel = SEL_AND;  // op 7 unused
    endcase
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import bitslice_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       less_i,
  input  logic       inv_a_i,
  input  logic       inv_b_i,
  input  logic       carry_i,
  input  slice_sel_e sel_i,
  output logic       res_o,
  output logic       carry_o,
  output logic       sign_o
);

  logic a_x, b_x, sum;

  assign a_x     = a_i ^ inv_a_i;
  assign b_x     = b_i ^ inv_b_i;
  assign sum     = a_x ^ b_x ^ carry_i;
  assign carry_o = (a_x & b_x) | (a_x & carry_i) | (b_x & carry_i);
  assign sign_o  = sum;

  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_x & b_x;
      SEL_OR:   res_o = a_x | b_x;
      SEL_SUM:  res_o = sum;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_msb_fix.sv
module alu_msb_fix (
  input  logic carry_in_msb_i,
  input  logic carry_out_msb_i,
  input  logic sign_msb_i,
  output logic ovf_o,
  output logic set_less_o
);

  assign ovf_o      = carry_in_msb_i ^ carry_out_msb_i;
  // raw sign is wrong exactly when the subtraction overflowed
  assign set_less_o = sign_msb_i ^ ovf_o;

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import bitslice_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             overflow_o
);

  localparam int MSB = WIDTH - 1;

  slice_ctrl_t ctrl;
  logic        ovf_raw;
  logic        set_less;
  logic        sign_msb;
  logic        carry_in_msb;
  logic        carry_out_msb;

  alu_ctrl_dec u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic cin, cout, res, less;

    if (i == 0) begin : g_lsb
      assign cin  = ctrl.carry0;
      assign less = set_less;
    end else begin : g_up
      assign cin  = g_slice[i-1].cout;
      assign less = 1'b0;
    end

    if (i == MSB) begin : g_top
      alu_slice u_slice (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .less_i  (less),
        .inv_a_i (ctrl.inv_a),
        .inv_b_i (ctrl.inv_b),
        .carry_i (cin),
        .sel_i   (ctrl.sel),
        .res_o   (res),
        .carry_o (cout),
        .sign_o  (sign_msb)
      );
      assign carry_in_msb  = cin;
      assign carry_out_msb = cout;
    end else begin : g_low
      logic sign_unused;
      alu_slice u_slice (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .less_i  (less),
        .inv_a_i (ctrl.inv_a),
        .inv_b_i (ctrl.inv_b),
        .carry_i (cin),
        .sel_i   (ctrl.sel),
        .res_o   (res),
        .carry_o (cout),
        .sign_o  (sign_unused)
      );
    end

    assign result_o[i] = res;
  end

  alu_msb_fix u_fix (
    .carry_in_msb_i  (carry_in_msb),
    .carry_out_msb_i (carry_out_msb),
    .sign_msb_i      (sign_msb),
    .ovf_o           (ovf_raw),
    .set_less_o      (set_less)
  );

  assign overflow_o = ctrl.ovf_en & ovf_raw;

endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk
  import bitslice_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             overflow_o
);

  always_comb begin
    if (op_i == 3'd2) begin
      AST_NAND_DEMORGAN: assert (result_o == ~(a_i & b_i)) else $error("nand mismatch"); // R3
    end
    if (op_i == 3'd3) begin
      AST_NOR_DEMORGAN: assert (result_o == ~(a_i | b_i)) else $error("nor mismatch"); // R4
    end
    if (op_i == 3'd4) begin
      AST_ADD_OVERFLOW: assert (overflow_o == ((a_i[WIDTH-1] == b_i[WIDTH-1]) && (result_o[WIDTH-1] != a_i[WIDTH-1]))) else $error("add ovf"); // R7
    end
    if (op_i == 3'd5) begin
      AST_SUB_OVERFLOW: assert (overflow_o == ((a_i[WIDTH-1] != b_i[WIDTH-1]) && (result_o[WIDTH-1] != a_i[WIDTH-1]))) else $error("sub ovf"); // R8
    end
    if (op_i == 3'd6) begin
      AST_SLT_SIGNED: assert (result_o == WIDTH'($signed(a_i) < $signed(b_i))) else $error("slt mismatch"); // R9
    end
    if (op_i <= 3'd3 || op_i == 3'd6) begin
      AST_NO_OVERFLOW: assert (!overflow_o) else $error("stray overflow"); // R10
    end
  end

endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .op_i       (op_i),
  .result_o   (result_o),
  .overflow_o (overflow_o)
);

// File: tb/bitslice_alu_test.sv
`timescale 1ns/1ps
module bitslice_alu_test;

  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic [2:0] op;
  logic [7:0] res;
  logic       ovf;
  int         checks = 0;
  int         failures = 0;
  int         cycles = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  bitslice_alu #(.WIDTH(8)) uut (
    .a_i        (a),
    .b_i        (b),
    .op_i       (op),
    .result_o   (res),
    .overflow_o (ovf)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s a=%02h b=%02h op=%0d got=%0h exp=%0h", tag, a, b, op, got, exp);
    end
  endtask

  task automatic apply(input logic [7:0] ta, input logic [7:0] tb, input logic [2:0] top);
    a  = ta;
    b  = tb;
    op = top;
    #0.5;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int sa, sb, ex_r, ex_v;
    string tr, tv;

    // R11: no state, zero inputs
    apply(8'h00, 8'h00, 3'd0);
    check("R11 result", int'(res), 0);
    check("R11 overflow", int'(ovf), 0);
    #0.5;

    for (int o = 0; o < 7; o++) begin
      for (int ia = 0; ia < 256; ia++) begin
        for (int ib = 0; ib < 256; ib++) begin
          sa = (ia > 127) ? ia - 256 : ia;
          sb = (ib > 127) ? ib - 256 : ib;
          ex_v = 0;
          tv = "R10";
          case (o)
            0: begin ex_r = ia & ib;          tr = "R1"; end
            1: begin ex_r = ia | ib;          tr = "R2"; end
            2: begin ex_r = ~(ia & ib) & 255; tr = "R3"; end
            3: begin ex_r = ~(ia | ib) & 255; tr = "R4"; end
            4: begin
              ex_r = (ia + ib) & 255; tr = "R5"; tv = "R7";
              ex_v = (sa + sb > 127 || sa + sb < -128) ? 1 : 0;
            end
            5: begin
              ex_r = (ia - ib) & 255; tr = "R6"; tv = "R8";
              ex_v = (sa - sb > 127 || sa - sb < -128) ? 1 : 0;
            end
            default: begin ex_r = (sa < sb) ? 1 : 0; tr = "R9"; end
          endcase
          apply(ia[7:0], ib[7:0], o[2:0]);
          check(tr, int'(res), ex_r);
          check(tv, int'(ovf), ex_v);
          #0.5;
        end
      end
    end

    // Directed extremes with hand-worked values
    apply(8'h7F, 8'h01, 3'd4); check("R7 7F+01", int'(ovf), 1); check("R5 7F+01", int'(res), 8'h80); #0.5;
    apply(8'hFF, 8'h01, 3'd4); check("R7 FF+01", int'(ovf), 0); check("R5 FF+01", int'(res), 0);   #0.5;
    apply(8'h80, 8'h01, 3'd5); check("R8 80-01", int'(ovf), 1); check("R6 80-01", int'(res), 8'h7F); #0.5;
    apply(8'h80, 8'h7F, 3'd6); check("R9 80<7F ovf", int'(res), 1); check("R10 slt", int'(ovf), 0);  #0.5;
    apply(8'h7F, 8'h80, 3'd6); check("R9 7F<80 ovf", int'(res), 0); #0.5;
    apply(8'hFF, 8'h00, 3'd6); check("R9 FF<00", int'(res), 1); #0.5;
    apply(8'h00, 8'hFF, 3'd6); check("R9 00<FF", int'(res), 0); #0.5;
    apply(8'h80, 8'h80, 3'd6); check("R9 equal", int'(res), 0); #0.5;
    apply(8'hFF, 8'h00, 3'd2); check("R3 FF nand 00", int'(res), 8'hFF); #0.5;
    apply(8'hFF, 8'h00, 3'd3); check("R4 FF nor 00", int'(res), 8'h00); #0.5;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule